// File: doc/BRIEF.md
# Interrupt Lifecycle Tracker with Acknowledge and End-of-Interrupt

This block holds the lifecycle state of every interrupt source that belongs to one processor core. It also presents the core with the most urgent of the sources that may be delivered. There are three classes of source. Software-raised sources are set by a write strobe carrying their ID. Private sources come in on active-low lines. Shared sources come in on active-high lines. Each private or shared source can be configured as level-sensitive or edge-triggered, and every source has its own priority and enable.

A source is always in one of four states: idle, waiting, in service, or in service with another request waiting. When the core raises an acknowledge request, the block returns the ID of the winning source and marks that source as in service. When the core later writes the same ID to the completion port, the block takes the source out of service. A mask register holds a threshold. Only sources whose priority value is strictly below the threshold are signalled or granted.

The default parameters give 8 software sources (IDs 0..7), 8 private sources (IDs 16..23) and 16 shared sources (IDs 32..47), each with an 8-bit priority.

Top module: `irq_state_tracker`

## Requirements
- R1: After synchronous reset, every source is idle and disabled, all priorities are 8'hFF and the mask is 0. As a result `irq_out` is 0 and an acknowledge returns the spurious ID 1023.
- R2: An edge-configured source becomes waiting on a rising transition of its asserted level. A new transition while the source is in service makes it in-service-and-waiting. A completion then returns it to waiting, so the next acknowledge grants it again.
- R3: A level-configured source is waiting exactly while its line is asserted and the source is not in service. If the line is still asserted after a completion, the source is waiting again.
- R4: Private line k (ID 16+k) is asserted when `ppi_n_i[k]` is 0. Shared line k (ID 32+k) is asserted when `spi_i[k]` is 1.
- R5: Software source n (ID n, n < 16) becomes waiting on a cycle with `sgi_we`=1 and `sgi_id`=n. It always behaves as edge-triggered, and `cfg_edge` has no effect on it.
- R6: Among the sources that are waiting, enabled and not in service, the one with the lowest priority value wins. On equal priority the lower ID wins.
- R7: `irq_out` is 1 only when the winner's priority is strictly less than the mask. The mask is loaded by `pmr_we` with `pmr_val`. When the winner is not below the mask, an acknowledge returns 1023.
- R8: `ack_valid` is high for exactly the cycle after `ack_req`, and `ack_id` then holds the granted ID (or 1023). The granted source goes into service and is not granted again until it completes.
- R9: `eoi_we` with `eoi_id` takes the matching source out of service. A completion naming a source that is not in service is ignored.
- R10: A source with enable 0 keeps its waiting state but is neither signalled nor granted. Setting enable to 1 makes it eligible again.
- R11: `cfg_we` writes `cfg_prio`, `cfg_en` and `cfg_edge` (1 = edge) to the source `cfg_id`. `irq_out` reflects a line change two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ppi_n_i | input | N_PPI | Private lines, active low |
| spi_i | input | N_SPI | Shared lines, active high |
| sgi_we | input | 1 | Raise a software source |
| sgi_id | input | 10 | ID of the software source to raise |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_id | input | 10 | ID of the source to configure |
| cfg_prio | input | PRIO_W | Priority (lower value is more urgent) |
| cfg_en | input | 1 | Enable |
| cfg_edge | input | 1 | 1 = edge, 0 = level |
| pmr_we | input | 1 | Mask write strobe |
| pmr_val | input | PRIO_W | Mask threshold |
| ack_req | input | 1 | Acknowledge request |
| eoi_we | input | 1 | Completion write strobe |
| eoi_id | input | 10 | ID being completed |
| irq_out | output | 1 | Interrupt signal to the core |
| ack_valid | output | 1 | Acknowledge result is valid |
| ack_id | output | 10 | Granted ID, or 1023 |

## Verification
A level source is driven in three ways: held through an acknowledge and completion, released before acknowledge, and released during service. This separates line-following from latched behaviour. Edge sources get single pulses and a second pulse during service, which shows whether the in-service-and-waiting state exists. Simultaneous requests with equal and different priorities expose errors in the ordering rule. A mask equal to the priority, disabled-then-enabled sources, and a software source configured as level probe the strict comparison, enable gating and fixed edge behaviour.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {CLS_SW, CLS_PRIV, CLS_SHARED} src_class_e;

  // Map a dense source index onto its externally visible ID
  function automatic int src_id(int idx, int n_sw, int n_priv);
    if (idx < n_sw) return idx;
    else if (idx < n_sw + n_priv) return 16 + (idx - n_sw);
    else return 32 + (idx - n_sw - n_priv);
  endfunction

  function automatic src_class_e src_class(int idx, int n_sw, int n_priv);
    if (idx < n_sw) return CLS_SW;
    else if (idx < n_sw + n_priv) return CLS_PRIV;
    else return CLS_SHARED;
  endfunction
endpackage

// File: rtl/irqt_cell.sv
module irqt_cell #(
  parameter int PRIO_W     = 8,
  parameter bit FIXED_EDGE = 1'b0,
  parameter bit ACT_LOW    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_raw,
  input  logic              sw_set,
  input  logic              cfg_hit,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_en,
  input  logic              cfg_edge,
  input  logic              ack_hit,
  input  logic              eoi_hit,
  output logic              pend_o,
  output logic              act_o,
  output logic              en_o,
  output logic [PRIO_W-1:0] prio_o
);
  logic asrt, prev_q, edge_q, act_n, trig;

  assign asrt  = ACT_LOW ? ~line_raw : line_raw;
  assign act_n = (act_o & ~eoi_hit) | ack_hit;
  assign trig  = sw_set | (asrt & ~prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
      act_o  <= 1'b0;
      en_o   <= 1'b0;
      edge_q <= FIXED_EDGE;
      prio_o <= '1;
    end else begin
      prev_q <= asrt;
      act_o  <= act_n;
      if (edge_q) pend_o <= (pend_o & ~ack_hit) | trig;
      else        pend_o <= asrt & ~act_n;
      if (cfg_hit) begin
        prio_o <= cfg_prio;
        en_o   <= cfg_en;
        edge_q <= cfg_edge | FIXED_EDGE;
      end
    end
  end
endmodule

// File: rtl/irqt_arb.sv
module irqt_arb #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        elig,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic                    best_valid,
  output logic [IDX_W-1:0]        best_idx,
  output logic [PRIO_W-1:0]       best_prio
);
  always_comb begin
    best_valid = 1'b0;
    best_idx   = '0;
    best_prio  = '1;
    // ascending scan with strict compare keeps the lowest ID on ties
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!best_valid || prio_flat[i*PRIO_W +: PRIO_W] < best_prio)) begin
        best_valid = 1'b1;
        best_idx   = IDX_W'(i);
        best_prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
  import irqt_pkg::*;
#(
  parameter int N_SGI  = 8,
  parameter int N_PPI  = 8,
  parameter int N_SPI  = 16,
  parameter int PRIO_W = 8,
  localparam int N_SRC = N_SGI + N_PPI + N_SPI,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PPI-1:0]  ppi_n_i,
  input  logic [N_SPI-1:0]  spi_i,
  input  logic              sgi_we,
  input  logic [ID_W-1:0]   sgi_id,
  input  logic              cfg_we,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_en,
  input  logic              cfg_edge,
  input  logic              pmr_we,
  input  logic [PRIO_W-1:0] pmr_val,
  input  logic              ack_req,
  input  logic              eoi_we,
  input  logic [ID_W-1:0]   eoi_id,
  output logic              irq_out,
  output logic              ack_valid,
  output logic [ID_W-1:0]   ack_id
);
  logic [N_SRC-1:0]        pend_vec, act_vec, en_vec, elig, ack_hit, eoi_hit;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [ID_W-1:0]         id_tab [N_SRC];
  logic [PRIO_W-1:0]       mask_q;
  logic                    best_valid, grant;
  logic [IDX_W-1:0]        best_idx;
  logic [PRIO_W-1:0]       best_prio;

  for (genvar i = 0; i < N_SRC; i++) begin : g_cell
    localparam src_class_e CLS = src_class(i, N_SGI, N_PPI);
    localparam logic [ID_W-1:0] CID = ID_W'(src_id(i, N_SGI, N_PPI));
    logic line, sw;
    if (CLS == CLS_SW) begin : g_sw
      assign line = 1'b0;
      assign sw   = sgi_we && (sgi_id == CID);
    end else if (CLS == CLS_PRIV) begin : g_priv
      assign line = ppi_n_i[i-N_SGI];
      assign sw   = 1'b0;
    end else begin : g_shared
      assign line = spi_i[i-N_SGI-N_PPI];
      assign sw   = 1'b0;
    end
    assign id_tab[i]  = CID;
    assign elig[i]    = pend_vec[i] & ~act_vec[i] & en_vec[i];
    assign ack_hit[i] = grant && (best_idx == IDX_W'(i));
    assign eoi_hit[i] = eoi_we && (eoi_id == CID) && act_vec[i];

    irqt_cell #(
      .PRIO_W(PRIO_W),
      .FIXED_EDGE(CLS == CLS_SW),
      .ACT_LOW(CLS == CLS_PRIV)
    ) u_cell (
      .clk     (clk),
      .rst     (rst),
      .line_raw(line),
      .sw_set  (sw),
      .cfg_hit (cfg_we && (cfg_id == CID)),
      .cfg_prio(cfg_prio),
      .cfg_en  (cfg_en),
      .cfg_edge(cfg_edge),
      .ack_hit (ack_hit[i]),
      .eoi_hit (eoi_hit[i]),
      .pend_o  (pend_vec[i]),
      .act_o   (act_vec[i]),
      .en_o    (en_vec[i]),
      .prio_o  (prio_flat[i*PRIO_W +: PRIO_W])
    );
  end

  irqt_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .elig      (elig),
    .prio_flat (prio_flat),
    .best_valid(best_valid),
    .best_idx  (best_idx),
    .best_prio (best_prio)
  );

  logic signal_ok;
  assign signal_ok = best_valid && (best_prio < mask_q);
  assign grant     = ack_req && signal_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      irq_out   <= 1'b0;
      ack_valid <= 1'b0;
      ack_id    <= SPURIOUS_ID;
    end else begin
      if (pmr_we) mask_q <= pmr_val;
      irq_out   <= signal_ok;
      ack_valid <= ack_req;
      if (ack_req) ack_id <= grant ? id_tab[best_idx] : SPURIOUS_ID;
    end
  end
endmodule

// File: rtl/irqt_chk.sv
module irqt_chk #(
  parameter int N_SRC  = 32,
  parameter int N_SGI  = 8,
  parameter int N_PPI  = 8,
  parameter int N_SPI  = 16,
  parameter int PRIO_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ack_req,
  input logic              ack_valid,
  input logic [9:0]        ack_id,
  input logic              irq_out,
  input logic [PRIO_W-1:0] mask_q,
  input logic [N_SRC-1:0]  ack_hit,
  input logic [N_SRC-1:0]  eoi_hit,
  input logic [N_SRC-1:0]  act_vec
);
  assert_ack_follows_R8: assert property (@(posedge clk) disable iff (rst)
    ack_req |=> ack_valid);

  assert_ack_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(ack_req));

  assert_grant_single_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_hit) && ((ack_hit & act_vec) == '0));

  assert_ack_id_mapped_R5: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (ack_id == 10'd1023 || ack_id < N_SGI ||
                   (ack_id >= 16 && ack_id < 16 + N_PPI) ||
                   (ack_id >= 32 && ack_id < 32 + N_SPI)));

  assert_eoi_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (eoi_hit != '0) |=> ((act_vec & $past(eoi_hit)) == '0));

  assert_mask_zero_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_q) == '0) |-> !irq_out);
endmodule

bind irq_state_tracker irqt_chk #(
  .N_SRC(N_SRC), .N_SGI(N_SGI), .N_PPI(N_PPI), .N_SPI(N_SPI), .PRIO_W(PRIO_W)
) u_chk (
  .clk(clk), .rst(rst), .ack_req(ack_req), .ack_valid(ack_valid),
  .ack_id(ack_id), .irq_out(irq_out), .mask_q(mask_q),
  .ack_hit(ack_hit), .eoi_hit(eoi_hit), .act_vec(act_vec)
);

// File: tb/sim_irq_state_tracker.sv
module sim_irq_state_tracker;
  localparam int NS = 8, NP = 8, NH = 16, PW = 8;

  logic clk = 0, rst = 1;
  logic [NP-1:0] ppi_n_i = '1;
  logic [NH-1:0] spi_i = '0;
  logic sgi_we = 0, cfg_we = 0, cfg_en = 0, cfg_edge = 0, pmr_we = 0, ack_req = 0, eoi_we = 0;
  logic [9:0] sgi_id = 0, cfg_id = 0, eoi_id = 0;
  logic [PW-1:0] cfg_prio = 0, pmr_val = 0;
  logic irq_out, ack_valid;
  logic [9:0] ack_id;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  irq_state_tracker #(.N_SGI(NS), .N_PPI(NP), .N_SPI(NH), .PRIO_W(PW)) u0 (
    .clk(clk), .rst(rst), .ppi_n_i(ppi_n_i), .spi_i(spi_i), .sgi_we(sgi_we),
    .sgi_id(sgi_id), .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_prio(cfg_prio),
    .cfg_en(cfg_en), .cfg_edge(cfg_edge), .pmr_we(pmr_we), .pmr_val(pmr_val),
    .ack_req(ack_req), .eoi_we(eoi_we), .eoi_id(eoi_id), .irq_out(irq_out),
    .ack_valid(ack_valid), .ack_id(ack_id));

  // ---------------- behavioural reference, indexed by ID ----------------
  int m_pend[64], m_act[64], m_prio[64], m_en[64], m_edge[64], m_prev[64];
  int m_mask = 0, e_irq = 0, e_av = 0, e_aid = 1023;

  function automatic bit mapped(int id);
    return (id < NS) || (id >= 16 && id < 16 + NP) || (id >= 32 && id < 32 + NH);
  endfunction

  function automatic int asserted(int id);
    if (id >= 16 && id < 32) return (ppi_n_i[id-16] == 1'b0) ? 1 : 0;
    if (id >= 32) return spi_i[id-32] ? 1 : 0;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int id = 0; id < 64; id++) begin
        m_pend[id] = 0; m_act[id] = 0; m_prio[id] = 255; m_en[id] = 0;
        m_edge[id] = 0; m_prev[id] = 0;
      end
      m_mask = 0; e_irq = 0; e_av = 0;
    end else begin
      int best, bp, sig;
      best = -1; bp = 1000;
      for (int id = 0; id < 64; id++)
        if (mapped(id) && m_pend[id] != 0 && m_act[id] == 0 && m_en[id] != 0 && m_prio[id] < bp) begin
          best = id; bp = m_prio[id];
        end
      sig = (best >= 0 && bp < m_mask) ? 1 : 0;
      e_irq = sig;
      e_av = ack_req;
      if (ack_req) e_aid = sig ? best : 1023;
      for (int id = 0; id < 64; id++) begin
        if (mapped(id)) begin
          int a, acked, done_eoi, nact;
          a = asserted(id);
          acked = (ack_req && sig != 0 && best == id) ? 1 : 0;
          done_eoi = (eoi_we && eoi_id == id && m_act[id] != 0) ? 1 : 0;
          nact = ((m_act[id] != 0 && done_eoi == 0) || acked != 0) ? 1 : 0;
          if (id < 16 || m_edge[id] != 0) begin
            int trig;
            trig = (id < 16) ? ((sgi_we && sgi_id == id) ? 1 : 0) : ((a != 0 && m_prev[id] == 0) ? 1 : 0);
            m_pend[id] = ((m_pend[id] != 0 && acked == 0) || trig != 0) ? 1 : 0;
          end else m_pend[id] = (a != 0 && nact == 0) ? 1 : 0;
          m_prev[id] = a; m_act[id] = nact;
          if (cfg_we && cfg_id == id) begin
            m_prio[id] = cfg_prio; m_en[id] = cfg_en;
            m_edge[id] = (id < 16) ? 1 : cfg_edge;
          end
        end
      end
      if (pmr_we) m_mask = pmr_val;
    end
  end

  always @(posedge clk) begin
    #5;
    if (!rst) begin
      checks++;
      if (irq_out !== e_irq[0] || ack_valid !== e_av[0] || (e_av != 0 && ack_id !== 10'(e_aid))) begin
        failures++;
        $display("FAIL %s model irq=%0b av=%0b id=%0d expected irq=%0d av=%0d id=%0d",
                 cur_req, irq_out, ack_valid, ack_id, e_irq, e_av, e_aid);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic cfg(int id, int prio, bit en, bit edg);
    @(negedge clk); cfg_we = 1; cfg_id = 10'(id); cfg_prio = 8'(prio); cfg_en = en; cfg_edge = edg;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_mask(int v);
    @(negedge clk); pmr_we = 1; pmr_val = 8'(v);
    @(negedge clk); pmr_we = 0;
  endtask

  task automatic do_ack(output int id);
    @(negedge clk); ack_req = 1;
    @(negedge clk); ack_req = 0; id = ack_id;
  endtask

  task automatic do_eoi(int id);
    @(negedge clk); eoi_we = 1; eoi_id = 10'(id);
    @(negedge clk); eoi_we = 0;
  endtask

  task automatic pulse_spi(logic [NH-1:0] m);
    @(negedge clk); spi_i = spi_i | m;
    @(negedge clk); spi_i = spi_i & ~m;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    cur_req = "R1";
    check("R1 irq after reset", irq_out, 0);
    do_ack(g); check("R1 ack after reset", g, 1023);

    // level shared source (R3, R4, R8, R9, R11)
    cur_req = "R3";
    set_mask(8'hF0);
    cfg(32, 10, 1, 0);
    @(negedge clk); spi_i[0] = 1;
    idle(3); check("R11 level asserted signals", irq_out, 1);
    spi_i[0] = 0;
    idle(3); check("R3 level released clears", irq_out, 0);
    spi_i[0] = 1; idle(3);
    cur_req = "R8";
    do_ack(g); check("R8 ack level id", g, 32);
    idle(2); check("R8 in service not signalled", irq_out, 0);
    cur_req = "R9";
    do_eoi(33); idle(3); check("R9 wrong eoi ignored", irq_out, 0);
    do_eoi(32); idle(3); check("R3 line held re-pends", irq_out, 1);
    do_ack(g); check("R3 re-ack id", g, 32);
    spi_i[0] = 0; do_eoi(32); idle(3);
    do_ack(g); check("R3 released during service", g, 1023);

    // private active-low (R4)
    cur_req = "R4";
    cfg(16, 20, 1, 0);
    idle(3); check("R4 private high is idle", irq_out, 0);
    ppi_n_i[0] = 0; idle(3);
    check("R4 private low asserts", irq_out, 1);
    do_ack(g); check("R4 private ack id", g, 16);
    ppi_n_i[0] = 1; do_eoi(16); idle(2);

    // edge with second edge during service (R2)
    cur_req = "R2";
    cfg(33, 5, 1, 1);
    pulse_spi(16'h0002); idle(2);
    check("R2 edge latched after pulse", irq_out, 1);
    do_ack(g); check("R2 first ack", g, 33);
    pulse_spi(16'h0002); idle(2);
    check("R2 active-and-pending not signalled", irq_out, 0);
    do_eoi(33); idle(2);
    do_ack(g); check("R2 eoi returns to pending", g, 33);
    do_eoi(33); idle(1);
    do_ack(g); check("R2 consumed edge", g, 1023);

    // software source, cfg_edge ignored (R5)
    cur_req = "R5";
    cfg(3, 30, 1, 0);
    @(negedge clk); sgi_we = 1; sgi_id = 3;
    @(negedge clk); sgi_we = 0; idle(2);
    do_ack(g); check("R5 software ack id", g, 3);
    do_eoi(3); idle(1);
    do_ack(g); check("R5 software consumed", g, 1023);

    // ordering (R6)
    cur_req = "R6";
    cfg(34, 40, 1, 1); cfg(35, 40, 1, 1); cfg(36, 39, 1, 1);
    pulse_spi(16'h001C); idle(2);
    do_ack(g); check("R6 lowest value wins", g, 36);
    do_ack(g); check("R6 tie lower id", g, 34);
    do_ack(g); check("R6 remaining", g, 35);
    do_eoi(34); do_eoi(35); do_eoi(36);

    // mask strict (R7)
    cur_req = "R7";
    cfg(37, 8'h50, 1, 1); set_mask(8'h50);
    pulse_spi(16'h0020); idle(3);
    check("R7 equal to mask quiet", irq_out, 0);
    do_ack(g); check("R7 masked ack spurious", g, 1023);
    set_mask(8'h51); idle(2);
    check("R7 below mask signals", irq_out, 1);
    do_ack(g); check("R7 ack after unmask", g, 37);
    do_eoi(37);

    // enable (R10)
    cur_req = "R10";
    set_mask(8'hF0);
    cfg(38, 1, 0, 1);
    pulse_spi(16'h0040); idle(3);
    check("R10 disabled quiet", irq_out, 0);
    do_ack(g); check("R10 disabled ack spurious", g, 1023);
    cfg(38, 1, 1, 1); idle(2);
    check("R10 enabled keeps pending", irq_out, 1);
    do_ack(g); check("R10 enabled ack", g, 38);
    do_eoi(38); idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule